// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block decides which of seven interrupt sources an 8-bit controller core services next. Each source has a request line, an enable bit and two priority bits. A single global enable bit gates all seven sources. The two priority bits give each source one of four levels. The arbiter picks the highest level that is waiting. Within that level it prefers the source with the lowest index. It then presents a registered request and the handler address to the core.

When the core accepts the address with an acknowledge strobe, several things happen. The arbiter marks that source's level as in service. It drops its request line. It pulses a per-source acknowledge bit, which the flag logic around the core uses to clear flags that hardware is allowed to clear. A small in-service mask holds the levels that are now running. While a level is running, only a strictly higher level can interrupt it. A return strobe from the core removes the highest running level, so the earlier threshold comes back into force.

Two source slots are shared. Each has a mode bit that chooses between an external pin request and an on-chip peripheral request. The serial slot requests when either its receive flag or its transmit flag is set. The arbiter never issues an acknowledge for the serial slot, so software must clear those flags.

Top module: `irq_arbiter4`

## Requirements
- R1: After reset, `irq_out` is 0, `src_ack` is 0 and no level is in service.
- R2: Source 4 requests when `ser_rx | ser_tx` is set. Source 5 takes `cmp_req` when `cmp_sel` is 1 and `ext_req[2]` otherwise. Source 6 takes `pwm_req` when `pwm_sel` is 1 and `ext_req[3]` otherwise. Sources 0..3 are, in index order, `ext_req[0]`, `tmr_ovf[0]`, `ext_req[1]`, `tmr_ovf[1]`.
- R3: A source takes part in arbitration only while its bit in `src_en` is 1 and `glob_en` is 1.
- R4: The level of source i is `{pri_hi[i], pri_lo[i]}`. Level 3 ranks highest and level 0 lowest. When several levels are waiting, the highest one wins.
- R5: Within a single level, the lowest source index wins.
- R6: Source index i maps to `vec_addr` 8'h03 + 8·i for i = 0..4. Source 5 maps to 8'h33 and source 6 to 8'h3B. The address 8'h2B is never presented.
- R7: `irq_out` and `vec_addr` rise one clock edge after an edge where an eligible request is seen and no vector is pending. Both stay unchanged until `vec_ack` is sampled.
- R8: When `vec_ack` is sampled with `irq_out` high, three things happen at that edge: `irq_out` goes low, `src_ack` pulses for exactly one cycle at bit i of the served source, and that source's level enters service. A `vec_ack` sampled while `irq_out` is low has no effect.
- R9: `src_ack[4]` (serial) is never asserted.
- R10: A request is presented only if its level is strictly higher than the highest level in service. Requests at that level or below wait.
- R11: A `ret_strobe` removes the highest level in service. If `vec_ack` and `ret_strobe` arrive in the same cycle, the removal happens first and the acknowledged level is then added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req | input | 4 | External pin request flags 0..3 |
| tmr_ovf | input | 2 | Timer 0/1 overflow flags |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| cmp_req | input | 1 | Comparator request |
| pwm_req | input | 1 | PWM-timer overflow request |
| cmp_sel | input | 1 | Source 5 takes the comparator request |
| pwm_sel | input | 1 | Source 6 takes the PWM-timer request |
| src_en | input | 7 | Per-source enable |
| glob_en | input | 1 | Global enable |
| pri_hi | input | 7 | Upper priority bit per source |
| pri_lo | input | 7 | Lower priority bit per source |
| vec_ack | input | 1 | Core accepts the presented vector |
| ret_strobe | input | 1 | Core leaves a handler |
| irq_out | output | 1 | Vector pending |
| vec_addr | output | 8 | Handler address |
| src_ack | output | 7 | One-cycle acknowledge per source |

## Verification
The arbiter's choice is due one edge after it sees the request, so a request driven between edges shows on `irq_out` and `vec_addr` just after the next rising edge. Taking a vector makes `irq_out` fall and `src_ack` pulse on the edge that samples `vec_ack`. A change to the in-service mask (from an acknowledge or a return) first affects arbitration at the edge after that. The behavioural model in the bench steps once per rising edge, using the same inputs the design samples there. The outputs are compared one nanosecond later, after every edge, and inputs are changed only at that point. The directed checks read the same post-edge samples.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
   typedef enum logic [2:0] {
      SRC_EXT0 = 3'd0, SRC_TMR0 = 3'd1, SRC_EXT1 = 3'd2, SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4, SRC_ALT2 = 3'd5, SRC_ALT3 = 3'd6
   } src_id_e;

   // Slot numbering skips the reserved slot; address = base + stride * slot.
   function automatic int unsigned slot_addr(int unsigned idx, int unsigned base,
                                             int unsigned stride, int unsigned resv);
      int unsigned slot;
      slot = (idx >= resv) ? idx + 1 : idx;
      return base + stride * slot;
   endfunction
endpackage

// File: rtl/irqa_req_mux.sv
module irqa_req_mux #(
   parameter int unsigned NUM_SRC = 7
) (
   input  logic [3:0]         ext_req,
   input  logic [1:0]         tmr_ovf,
   input  logic               ser_rx,
   input  logic               ser_tx,
   input  logic               cmp_req,
   input  logic               pwm_req,
   input  logic               cmp_sel,
   input  logic               pwm_sel,
   output logic [NUM_SRC-1:0] req
);
   import irqa_pkg::*;

   initial begin
      if (NUM_SRC != 7) $error("irqa_req_mux: source map is built for seven sources");
   end

   always_comb begin
      req                 = '0;
      req[int'(SRC_EXT0)] = ext_req[0];
      req[int'(SRC_TMR0)] = tmr_ovf[0];
      req[int'(SRC_EXT1)] = ext_req[1];
      req[int'(SRC_TMR1)] = tmr_ovf[1];
      req[int'(SRC_SER)]  = ser_rx | ser_tx;
      req[int'(SRC_ALT2)] = cmp_sel ? cmp_req : ext_req[2];
      req[int'(SRC_ALT3)] = pwm_sel ? pwm_req : ext_req[3];
   end
endmodule

// File: rtl/irqa_level_stack.sv
module irqa_level_stack #(
   parameter int unsigned NUM_LVL = 4,
   localparam int unsigned LVL_W  = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [LVL_W-1:0]   set_lvl,
   input  logic               pop,
   output logic [NUM_LVL-1:0] in_svc,
   output logic [NUM_LVL-1:0] allow
);
   logic [NUM_LVL-1:0] svc_q;
   logic [NUM_LVL-1:0] top_bit;
   logic [NUM_LVL-1:0] set_bit;
   logic [NUM_LVL-1:0] svc_d;

   initial begin
      if (NUM_LVL < 2) $error("irqa_level_stack: need at least two levels");
      if ((1 << LVL_W) != NUM_LVL) $error("irqa_level_stack: level count must be a power of two");
   end

   // Highest set bit of the mask (the running level).
   always_comb begin
      logic found;
      top_bit = '0;
      found   = 1'b0;
      for (int l = NUM_LVL - 1; l >= 0; l--) begin
         if (!found && svc_q[l]) begin
            top_bit[l] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   // allow[l]: no level l or above is in service.
   always_comb begin
      for (int l = 0; l < NUM_LVL; l++) begin
         allow[l] = 1'b1;
         for (int k = l; k < NUM_LVL; k++) begin
            if (svc_q[k]) allow[l] = 1'b0;
         end
      end
   end

   always_comb begin
      set_bit = '0;
      if (set_en) set_bit[set_lvl] = 1'b1;
      svc_d = (svc_q & ~(pop ? top_bit : '0)) | set_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) svc_q <= '0;
      else        svc_q <= svc_d;
   end

   assign in_svc = svc_q;

   AST_POP_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !set_en && (svc_q != '0)) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1)); // R11
   AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> svc_q[$past(set_lvl)]); // R8
endmodule

// File: rtl/irqa_pick.sv
module irqa_pick #(
   parameter int unsigned NUM_SRC = 7,
   parameter int unsigned NUM_LVL = 4,
   localparam int unsigned LVL_W  = $clog2(NUM_LVL),
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] pri_hi,
   input  logic [NUM_SRC-1:0] pri_lo,
   input  logic [NUM_LVL-1:0] allow,
   output logic               win_vld,
   output logic [IDX_W-1:0]   win_idx,
   output logic [LVL_W-1:0]   win_lvl
);
   logic [LVL_W-1:0]   src_lvl [NUM_SRC];
   logic [NUM_SRC-1:0] elig;

   initial begin
      if (LVL_W != 2) $error("irqa_pick: priority is formed from exactly two bits");
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign src_lvl[s] = {pri_hi[s], pri_lo[s]};
      assign elig[s]    = req[s] & src_en[s] & glob_en & allow[src_lvl[s]];
   end

   // Highest level first; within a level, lowest index first.
   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int l = NUM_LVL - 1; l >= 0; l--) begin
         for (int s = 0; s < NUM_SRC; s++) begin
            if (!win_vld && elig[s] && (src_lvl[s] == LVL_W'(l))) begin
               win_vld = 1'b1;
               win_idx = IDX_W'(s);
               win_lvl = LVL_W'(l);
            end
         end
      end
   end

   AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> !win_vld); // R3
   AST_WIN_IS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> (src_en[win_idx] && req[win_idx])); // R3
endmodule

// File: rtl/irq_arbiter4.sv
module irq_arbiter4 #(
   parameter int unsigned NUM_SRC    = 7,
   parameter int unsigned NUM_LVL    = 4,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned RSV_SLOT   = 5,
   parameter int unsigned SER_IDX    = 4,
   localparam int unsigned LVL_W     = $clog2(NUM_LVL),
   localparam int unsigned IDX_W     = $clog2(NUM_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ext_req,
   input  logic [1:0]       tmr_ovf,
   input  logic             ser_rx,
   input  logic             ser_tx,
   input  logic             cmp_req,
   input  logic             pwm_req,
   input  logic             cmp_sel,
   input  logic             pwm_sel,
   input  logic [6:0]       src_en,
   input  logic             glob_en,
   input  logic [6:0]       pri_hi,
   input  logic [6:0]       pri_lo,
   input  logic             vec_ack,
   input  logic             ret_strobe,
   output logic             irq_out,
   output logic [VEC_W-1:0] vec_addr,
   output logic [6:0]       src_ack
);
   import irqa_pkg::*;

   localparam logic [VEC_W-1:0] RSV_ADDR = VEC_W'(VEC_BASE + VEC_STRIDE * RSV_SLOT);

   initial begin
      if (NUM_SRC != 7) $error("irq_arbiter4: port widths assume seven sources");
      if (SER_IDX >= NUM_SRC) $error("irq_arbiter4: serial index out of range");
      if (VEC_BASE + VEC_STRIDE * NUM_SRC >= (1 << VEC_W))
         $error("irq_arbiter4: vector table does not fit VEC_W");
   end

   logic [NUM_SRC-1:0] req;
   logic [NUM_LVL-1:0] in_svc;
   logic [NUM_LVL-1:0] allow;
   logic               win_vld;
   logic [IDX_W-1:0]   win_idx;
   logic [LVL_W-1:0]   win_lvl;

   logic               pend_q;
   logic [IDX_W-1:0]   pidx_q;
   logic [LVL_W-1:0]   plvl_q;
   logic [VEC_W-1:0]   vec_q;
   logic [NUM_SRC-1:0] ack_q;
   logic               take;
   logic [VEC_W-1:0]   win_addr;
   logic [NUM_SRC-1:0] ack_d;

   irqa_req_mux #(.NUM_SRC(NUM_SRC)) u_mux (
      .ext_req (ext_req), .tmr_ovf (tmr_ovf), .ser_rx (ser_rx), .ser_tx (ser_tx),
      .cmp_req (cmp_req), .pwm_req (pwm_req), .cmp_sel (cmp_sel), .pwm_sel (pwm_sel),
      .req     (req)
   );

   irqa_pick #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_pick (
      .clk (clk), .rst_n (rst_n), .req (req), .src_en (src_en), .glob_en (glob_en),
      .pri_hi (pri_hi), .pri_lo (pri_lo), .allow (allow),
      .win_vld (win_vld), .win_idx (win_idx), .win_lvl (win_lvl)
   );

   assign take = pend_q & vec_ack;

   irqa_level_stack #(.NUM_LVL(NUM_LVL)) u_stack (
      .clk (clk), .rst_n (rst_n), .set_en (take), .set_lvl (plvl_q),
      .pop (ret_strobe), .in_svc (in_svc), .allow (allow)
   );

   always_comb begin
      win_addr = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (win_idx == IDX_W'(s))
            win_addr = VEC_W'(slot_addr(s, VEC_BASE, VEC_STRIDE, RSV_SLOT));
      end
   end

   // Acknowledge pulse for the served source; the serial slot never clears in hardware.
   always_comb begin
      ack_d = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (take && (pidx_q == IDX_W'(s)) && (s != SER_IDX)) ack_d[s] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pidx_q <= '0;
         plvl_q <= '0;
         vec_q  <= '0;
         ack_q  <= '0;
      end else begin
         ack_q <= ack_d;
         if (take) begin
            pend_q <= 1'b0;
         end else if (!pend_q && win_vld) begin
            pend_q <= 1'b1;
            pidx_q <= win_idx;
            plvl_q <= win_lvl;
            vec_q  <= win_addr;
         end
      end
   end

   assign irq_out  = pend_q;
   assign vec_addr = vec_q;
   assign src_ack  = ack_q;

   AST_HOLD_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !vec_ack) |=> (pend_q && $stable(vec_q))); // R7
   AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && vec_ack) |=> !pend_q); // R8
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_q)); // R8
   AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q != '0) |-> $past(pend_q && vec_ack)); // R8
   AST_NO_RSV_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (vec_q != RSV_ADDR)); // R6
   AST_NEST_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> allow[plvl_q]); // R10
endmodule

// File: tb/irq_arbiter4_test.sv
module irq_arbiter4_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ext_req = '0;
   logic [1:0] tmr_ovf = '0;
   logic       ser_rx = 0, ser_tx = 0, cmp_req = 0, pwm_req = 0, cmp_sel = 0, pwm_sel = 0;
   logic [6:0] src_en = '1;
   logic       glob_en = 1'b1;
   logic [6:0] pri_hi = '0, pri_lo = '0;
   logic       vec_ack = 0, ret_strobe = 0;
   logic       irq_out;
   logic [7:0] vec_addr;
   logic [6:0] src_ack;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   string tag = "R1";

   // Behavioural reference model state
   bit        m_pend;
   int        m_idx, m_lvl;
   logic [7:0] m_vec;
   bit [6:0]  m_ack;
   bit        m_svc [4];

   always #2 clk = ~clk;

   irq_arbiter4 uut (
      .clk (clk), .rst_n (rst_n), .ext_req (ext_req), .tmr_ovf (tmr_ovf),
      .ser_rx (ser_rx), .ser_tx (ser_tx), .cmp_req (cmp_req), .pwm_req (pwm_req),
      .cmp_sel (cmp_sel), .pwm_sel (pwm_sel), .src_en (src_en), .glob_en (glob_en),
      .pri_hi (pri_hi), .pri_lo (pri_lo), .vec_ack (vec_ack), .ret_strobe (ret_strobe),
      .irq_out (irq_out), .vec_addr (vec_addr), .src_ack (src_ack)
   );

   function automatic bit m_req(int i);
      case (i)
         0: return ext_req[0];
         1: return tmr_ovf[0];
         2: return ext_req[1];
         3: return tmr_ovf[1];
         4: return ser_rx || ser_tx;                  // R2
         5: return cmp_sel ? cmp_req : ext_req[2];    // R2
         default: return pwm_sel ? pwm_req : ext_req[3];
      endcase
   endfunction

   function automatic logic [7:0] m_addr(int i);
      logic [7:0] tbl [7] = '{8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h33, 8'h3B}; // R6
      return tbl[i];
   endfunction

   function automatic int m_top();
      for (int l = 3; l >= 0; l--) if (m_svc[l]) return l;
      return -1;
   endfunction

   task automatic model_step();
      int top;
      bit hit;
      m_ack = '0;
      if (!rst_n) begin
         m_pend = 0; m_vec = '0;
         for (int l = 0; l < 4; l++) m_svc[l] = 0;
         return;
      end
      top = m_top();
      if (m_pend && vec_ack) begin
         if (ret_strobe && top >= 0) m_svc[top] = 0;      // R11 pop first
         m_svc[m_lvl] = 1;
         if (m_idx != 4) m_ack[m_idx] = 1;                 // R9
         m_pend = 0;
      end else begin
         if (!m_pend) begin
            hit = 0;
            for (int l = 3; l >= 0; l--)
               for (int i = 0; i < 7; i++) begin
                  if (!hit && m_req(i) && src_en[i] && glob_en &&
                      (int'({pri_hi[i], pri_lo[i]}) == l) && l > top) begin
                     hit = 1; m_pend = 1; m_idx = i; m_lvl = l; m_vec = m_addr(i);
                  end
               end
         end
         if (ret_strobe && top >= 0) m_svc[top] = 0;
      end
   endtask

   task automatic check(string t, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      #1;
      check({tag, " irq_out"}, {7'b0, irq_out}, {7'b0, m_pend});
      if (m_pend) check({tag, " vec_addr"}, vec_addr, m_vec);
      check({tag, " src_ack"}, {1'b0, src_ack}, {1'b0, m_ack});
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) cyc();
   endtask

   task automatic quiet();
      ext_req = '0; tmr_ovf = '0; ser_rx = 0; ser_tx = 0; cmp_req = 0; pwm_req = 0;
   endtask

   // Accept the pending vector, clear the requests, then leave the handler.
   task automatic serve_and_return();
      vec_ack = 1; cyc(); vec_ack = 0; quiet();
      ret_strobe = 1; cyc(); ret_strobe = 0; cyc();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset
      tag = "R1"; run(2);
      check("R1 irq_out", {7'b0, irq_out}, 8'h00);
      check("R1 src_ack", {1'b0, src_ack}, 8'h00);
      rst_n = 1; run(2);

      // R4 highest level wins; R7 one edge latency; R8 ack pulse; R10 masking
      tag = "R4";
      pri_lo[1] = 1; pri_hi[2] = 1;            // tmr0 level 1, ext1 level 2
      tmr_ovf[0] = 1; ext_req[1] = 1;
      check("R7 not before edge", {7'b0, irq_out}, 8'h00);
      cyc();
      check("R4 vec", vec_addr, 8'h13);
      tag = "R7"; run(3);
      check("R7 held", vec_addr, 8'h13);
      tag = "R8"; vec_ack = 1; cyc(); vec_ack = 0; ext_req[1] = 0;
      check("R8 ack bit", {1'b0, src_ack}, 8'h04);
      check("R8 irq drop", {7'b0, irq_out}, 8'h00);
      tag = "R10"; run(3);
      check("R10 blocked lower", {7'b0, irq_out}, 8'h00);
      ret_strobe = 1; cyc(); ret_strobe = 0; cyc();
      check("R11 threshold restored", vec_addr, 8'h0B);
      tag = "R8"; serve_and_return();
      pri_hi = '0; pri_lo = '0;

      // R5 tie inside a level
      tag = "R5"; tmr_ovf[1] = 1; ext_req[0] = 1; cyc();
      check("R5 tie", vec_addr, 8'h03);
      serve_and_return();
      pri_hi = 7'h7F; pri_lo = 7'h7F;
      tmr_ovf = 2'b11; cyc();
      check("R5 tie lvl3", vec_addr, 8'h0B);
      serve_and_return();
      pri_hi = '0; pri_lo = '0;

      // R6 each source alone
      tag = "R6";
      for (int i = 0; i < 7; i++) begin
         case (i)
            0: ext_req[0] = 1; 1: tmr_ovf[0] = 1; 2: ext_req[1] = 1;
            3: tmr_ovf[1] = 1; 4: ser_tx = 1; 5: ext_req[2] = 1;
            default: ext_req[3] = 1;
         endcase
         cyc();
         check("R6 vector", vec_addr, m_addr(i));
         tag = (i == 4) ? "R9" : "R6";
         serve_and_return();
      end

      // R2 alternate sources and serial OR
      tag = "R2";
      cmp_sel = 1; ext_req[2] = 1; run(2);
      check("R2 ext2 ignored when cmp_sel", {7'b0, irq_out}, 8'h00);
      cmp_req = 1; cyc();
      check("R2 comparator", vec_addr, 8'h33);
      serve_and_return();
      pwm_sel = 1; pwm_req = 1; cyc();
      check("R2 pwm", vec_addr, 8'h3B);
      serve_and_return();
      cmp_sel = 0; pwm_sel = 0;
      ser_rx = 1; cyc();
      check("R2 serial rx", vec_addr, 8'h23);
      tag = "R9"; vec_ack = 1; cyc(); vec_ack = 0; quiet();
      check("R9 no serial ack", {1'b0, src_ack}, 8'h00);
      ret_strobe = 1; cyc(); ret_strobe = 0;

      // R3 enables
      tag = "R3";
      glob_en = 0; ext_req[0] = 1; run(3);
      check("R3 global off", {7'b0, irq_out}, 8'h00);
      glob_en = 1; src_en[0] = 0; run(2);
      check("R3 source off", {7'b0, irq_out}, 8'h00);
      src_en[0] = 1; cyc();
      check("R3 enabled", vec_addr, 8'h03);
      serve_and_return();

      // R8 stray acknowledge while idle
      tag = "R8"; vec_ack = 1; run(2); vec_ack = 0;
      check("R8 idle ack", {1'b0, src_ack}, 8'h00);

      // R10 nesting, R11 pop order and combined ack+return
      tag = "R10";
      pri_hi[1] = 1; pri_lo[1] = 0;            // tmr0 level 2
      pri_hi[3] = 1; pri_lo[3] = 1;            // tmr1 level 3
      pri_lo[0] = 1;                           // ext0 level 1
      tmr_ovf[0] = 1; cyc(); vec_ack = 1; cyc(); vec_ack = 0; tmr_ovf[0] = 0;
      ext_req[0] = 1; run(2);
      check("R10 lower waits", {7'b0, irq_out}, 8'h00);
      tmr_ovf[1] = 1; cyc();
      check("R10 higher nests", vec_addr, 8'h1B);
      tag = "R11"; vec_ack = 1; ret_strobe = 1; cyc(); vec_ack = 0; ret_strobe = 0;
      tmr_ovf[1] = 0; run(2);   // level2 popped, level3 set: ext0 still waits
      check("R11 combined", {7'b0, irq_out}, 8'h00);
      ret_strobe = 1; cyc(); ret_strobe = 0; cyc();
      check("R11 released", vec_addr, 8'h03);
      serve_and_return();
      run(4);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule